// File: doc/BRIEF.md
# Reference-Disciplined Millisecond Tick Generator

This block turns a free-running local oscillator into an evenly spaced 1 kHz tick whose rate follows the oscillator's measured frequency rather than its nominal one. It counts oscillator cycles between consecutive rising edges of an external one-pulse-per-second reference and keeps the last eight accepted counts in a sliding window. The mean of that window is the block's estimate of cycles per second. A phase-accumulator divider then spreads exactly `TICK_HZ` ticks over each estimated second, with no hardware divide.

Reference edges are brought into the oscillator domain through a two-flop synchronizer. An interval whose count strays from the current estimate by more than a tolerance is treated as a glitch: its edge is ignored and the interval keeps running. If the reference is declared invalid, or if no usable edge arrives within one and a half estimated seconds, the block enters holdover. In holdover it keeps ticking from the last estimate and raises a status bit until a new interval is accepted.

Top module: `pps_ms_tick`

## Requirements
- R1: During and directly after reset, `tick_o` is 0, `freq_o` equals `NOM_HZ` and `holdover_o` is 1.
- R2: A measured count is the number of clock cycles between two successive rising edges of `pps_i`, each sampled through a two-flop synchronizer. The first edge after reset, after a timeout or after `ref_valid_i` returns only starts a new measurement.
- R3: `freq_o` is the floor of the sum of the last 8 accepted counts divided by 8 and is updated at each accepted edge. Until 8 counts have been accepted it stays at `NOM_HZ`.
- R4: A count whose absolute difference from `freq_o` exceeds `freq_o >> TOL_SHIFT` is rejected. It changes neither `freq_o` nor the window, and the offending edge does not restart the interval count.
- R5: `tick_o` is a one-cycle pulse from a phase accumulator. Each cycle the accumulator adds `TICK_HZ*8`. When the result reaches the divisor, which is the window sum (or `NOM_HZ*8` before the window is full), the divisor is subtracted and a tick is issued.
- R6: Ticks continue at the last estimate while `ref_valid_i` is low or the reference is missing. Over `freq_o` cycles there are `TICK_HZ` ticks, give or take one.
- R7: `holdover_o` rises when the interval count reaches `freq_o + (freq_o >> 1)` without an accepted edge. That timeout also drops the reference lock. `holdover_o` falls only at an accepted count.
- R8: While `ref_valid_i` is low, `holdover_o` is 1 from the next cycle on and `pps_i` edges are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Local oscillator clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| pps_i | input | 1 | Reference one-pulse-per-second, asynchronous |
| ref_valid_i | input | 1 | Reference valid flag, synchronous to clk_i |
| tick_o | output | 1 | One-cycle tick at TICK_HZ |
| freq_o | output | $clog2(NOM_HZ*4) | Averaged cycles-per-second estimate |
| holdover_o | output | 1 | High while running without an accepted reference |

## Verification
A corrupted window entry or sum shows at `freq_o` in the cycle after the next accepted edge. It also shows as a drift of the tick spacing within a few ticks. A wrong interval counter or a missed rejection appears as a wrong average one reference second later. A faulty timeout shows as `holdover_o` changing in the wrong cycle. A behavioural model compares all three outputs on every cycle, so any divergence is reported at the first cycle it reaches a port.

// File: rtl/pps_tick_pkg.sv
package pps_tick_pkg;
  // |a - b| <= b >> shift, evaluated on 32-bit values
  function automatic logic within_tol(input logic [31:0] meas, input logic [31:0] est,
                                      input int unsigned shift);
    logic [31:0] diff;
    diff = (meas > est) ? meas - est : est - meas;
    return diff <= (est >> shift);
  endfunction
endpackage

// File: rtl/pps_edge_sync.sv
module pps_edge_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pps_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sh_q <= '0;
    else         sh_q <= {sh_q[STAGES-1:0], pps_i};
  end

  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pps_period_meter.sv
module pps_period_meter
  import pps_tick_pkg::*;
#(
  parameter int unsigned CNT_W     = 27,
  parameter int unsigned TOL_SHIFT = 13
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rise_i,
  input  logic             ref_valid_i,
  input  logic [CNT_W-1:0] est_i,
  output logic             accept_o,
  output logic [CNT_W-1:0] meas_o,
  output logic             holdover_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             have_ref_q, hold_q;
  logic             in_tol;
  logic [CNT_W:0]   timeout;

  assign meas_o   = cnt_q + CNT_W'(1);
  assign in_tol   = within_tol(32'(meas_o), 32'(est_i), TOL_SHIFT);
  assign timeout  = {1'b0, est_i} + {2'b0, est_i[CNT_W-1:1]};
  assign accept_o = ref_valid_i & rise_i & have_ref_q & in_tol;
  assign holdover_o = hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q      <= '0;
      have_ref_q <= 1'b0;
      hold_q     <= 1'b1;
    end else if (!ref_valid_i) begin
      cnt_q      <= '0;
      have_ref_q <= 1'b0;
      hold_q     <= 1'b1;
    end else if (rise_i && (!have_ref_q || in_tol)) begin
      cnt_q      <= '0;
      have_ref_q <= 1'b1;
      if (have_ref_q) hold_q <= 1'b0;
    end else if ({1'b0, cnt_q} == timeout) begin
      // no usable edge for 1.5 s: drop lock, freeze counter
      hold_q     <= 1'b1;
      have_ref_q <= 1'b0;
    end else begin
      cnt_q <= cnt_q + CNT_W'(1);
    end
  end

  a_r8_invalid_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_valid_i |=> hold_q);
  a_r7_accept_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> !hold_q);
  a_r2_accept_restarts: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept_o |=> (cnt_q == '0));
  a_r8_no_accept_invalid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ref_valid_i |=> !have_ref_q);
endmodule

// File: rtl/pps_avg_window.sv
module pps_avg_window #(
  parameter int unsigned CNT_W  = 27,
  parameter int unsigned WIN_LG = 3,
  parameter int unsigned NOM_HZ = 25_000_000
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    push_i,
  input  logic [CNT_W-1:0]        meas_i,
  output logic [CNT_W-1:0]        est_o,
  output logic [CNT_W+WIN_LG-1:0] div_sum_o
);
  localparam int unsigned WIN_N = 1 << WIN_LG;
  localparam int unsigned SUM_W = CNT_W + WIN_LG;

  logic [CNT_W-1:0]  win_q [WIN_N];
  logic [WIN_LG-1:0] ptr_q;
  logic [WIN_LG:0]   fill_q;
  logic [SUM_W-1:0]  sum_q;
  logic              full;

  assign full = (fill_q == (WIN_LG+1)'(WIN_N));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < WIN_N; i++) win_q[i] <= '0;
      ptr_q  <= '0;
      fill_q <= '0;
      sum_q  <= '0;
    end else if (push_i) begin
      win_q[ptr_q] <= meas_i;
      ptr_q        <= ptr_q + WIN_LG'(1);
      sum_q        <= sum_q + SUM_W'(meas_i) - SUM_W'(win_q[ptr_q]);
      if (!full) fill_q <= fill_q + (WIN_LG+1)'(1);
    end
  end

  assign est_o     = full ? CNT_W'(sum_q >> WIN_LG) : CNT_W'(NOM_HZ);
  assign div_sum_o = full ? sum_q : (SUM_W'(NOM_HZ) << WIN_LG);

  always_ff @(posedge clk_i) begin
    if (rst_ni) a_r3_fill_range: assert (fill_q <= (WIN_LG+1)'(WIN_N));
  end
endmodule

// File: rtl/pps_frac_divider.sv
module pps_frac_divider #(
  parameter int unsigned SUM_W   = 30,
  parameter int unsigned TICK_HZ = 1000,
  parameter int unsigned WIN_LG  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [SUM_W-1:0] div_sum_i,
  output logic             tick_o
);
  localparam int unsigned ACC_W = SUM_W + 1;
  localparam logic [ACC_W-1:0] INC = ACC_W'(TICK_HZ) << WIN_LG;

  logic [ACC_W-1:0] acc_q, nxt;
  logic             tick_q, wrap;

  assign nxt  = acc_q + INC;
  assign wrap = nxt >= {1'b0, div_sum_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      acc_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      acc_q  <= wrap ? nxt - {1'b0, div_sum_i} : nxt;
      tick_q <= wrap;
    end
  end

  assign tick_o = tick_q;

  a_r5_acc_moves: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wrap |=> acc_q == $past(acc_q) + INC);
endmodule

// File: rtl/pps_ms_tick.sv
module pps_ms_tick #(
  parameter int unsigned NOM_HZ      = 25_000_000,
  parameter int unsigned TICK_HZ     = 1000,
  parameter int unsigned WIN_LG      = 3,
  parameter int unsigned TOL_SHIFT   = 13,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          pps_i,
  input  logic                          ref_valid_i,
  output logic                          tick_o,
  output logic [$clog2(NOM_HZ*4)-1:0]   freq_o,
  output logic                          holdover_o
);
  localparam int unsigned CNT_W = $clog2(NOM_HZ*4);
  localparam int unsigned SUM_W = CNT_W + WIN_LG;

  logic             rise, accept;
  logic [CNT_W-1:0] meas, est;
  logic [SUM_W-1:0] div_sum;

  pps_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .pps_i, .rise_o(rise)
  );

  pps_period_meter #(.CNT_W(CNT_W), .TOL_SHIFT(TOL_SHIFT)) u_meter (
    .clk_i, .rst_ni, .rise_i(rise), .ref_valid_i, .est_i(est),
    .accept_o(accept), .meas_o(meas), .holdover_o
  );

  pps_avg_window #(.CNT_W(CNT_W), .WIN_LG(WIN_LG), .NOM_HZ(NOM_HZ)) u_win (
    .clk_i, .rst_ni, .push_i(accept), .meas_i(meas), .est_o(est), .div_sum_o(div_sum)
  );

  pps_frac_divider #(.SUM_W(SUM_W), .TICK_HZ(TICK_HZ), .WIN_LG(WIN_LG)) u_div (
    .clk_i, .rst_ni, .div_sum_i(div_sum), .tick_o
  );

  assign freq_o = est;
endmodule

// File: tb/pps_ms_tick_tb.sv
module pps_ms_tick_tb;
  localparam int NOM = 3000;
  localparam int TSH = 5;
  localparam int FW  = $clog2(NOM*4);

  logic clk = 0, rst_n = 0, pps = 0, rv = 0;
  logic tick;
  logic [FW-1:0] freq;
  logic hold;

  pps_ms_tick #(.NOM_HZ(NOM), .TICK_HZ(1000), .WIN_LG(3), .TOL_SHIFT(TSH)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .pps_i(pps), .ref_valid_i(rv),
    .tick_o(tick), .freq_o(freq), .holdover_o(hold)
  );

  always #5 clk = ~clk;

  int total = 0, bad = 0, tick_seen = 0;
  bit done = 0;

  // behavioural reference model
  bit m_p1, m_p2, m_p3, m_have, m_hold = 1, m_tick;
  int m_cnt, m_acc;
  int q[$];

  function automatic int m_sum();
    int s = 0;
    foreach (q[i]) s += q[i];
    return s;
  endfunction
  function automatic int m_est();
    return (q.size() == 8) ? m_sum() / 8 : NOM;
  endfunction
  function automatic int m_dsum();
    return (q.size() == 8) ? m_sum() : NOM * 8;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_p1 = 0; m_p2 = 0; m_p3 = 0; m_have = 0; m_hold = 1; m_tick = 0;
      m_cnt = 0; m_acc = 0; q.delete();
    end else begin
      int est, dsum, meas, diff, nxt;
      bit rise, intol;
      est = m_est(); dsum = m_dsum();
      rise = m_p2 && !m_p3;
      meas = m_cnt + 1;
      diff = (meas > est) ? meas - est : est - meas;
      intol = diff <= (est >> TSH);
      if (!rv) begin
        m_cnt = 0; m_have = 0; m_hold = 1;
      end else if (rise && (!m_have || intol)) begin
        if (m_have) begin
          q.push_back(meas);
          if (q.size() > 8) void'(q.pop_front());
          m_hold = 0;
        end
        m_cnt = 0; m_have = 1;
      end else if (m_cnt == est + est / 2) begin
        m_hold = 1; m_have = 0;
      end else m_cnt++;
      nxt = m_acc + 8000;
      if (nxt >= dsum) begin m_acc = nxt - dsum; m_tick = 1; end
      else begin m_acc = nxt; m_tick = 0; end
      m_p3 = m_p2; m_p2 = m_p1; m_p1 = pps;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(tick == m_tick, "R5 tick", tick, m_tick);
      chk(int'(freq) == m_est(), "R3 freq", freq, m_est());
      chk(hold == m_hold, "R7 holdover", hold, m_hold);
      if (tick) tick_seen++;
    end
  end

  task automatic pulse_gap(input int period);
    pps = 1;
    repeat (2) @(negedge clk);
    pps = 0;
    repeat (period - 2) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(tick == 0, "R1 tick reset", tick, 0);
    chk(int'(freq) == NOM, "R1 freq reset", freq, NOM);
    chk(hold == 1, "R1 holdover reset", hold, 1);
    rst_n = 1;
    @(negedge clk);
    chk(int'(freq) == NOM && hold, "R1 after release", freq, NOM);
    rv = 1;
    for (int i = 0; i < 10; i++) begin
      pulse_gap(3002);
      if (i == 3) chk(int'(freq) == NOM, "R3 nominal until full", freq, NOM);
      if (i == 1) chk(hold == 0, "R2 second edge accepted", hold, 0);
    end
    chk(int'(freq) == 3002, "R3 window average", freq, 3002);
    // glitch edge in the middle of an interval
    pulse_gap(1500);
    pulse_gap(1502);
    chk(int'(freq) == 3002, "R4 glitch rejected", freq, 3002);
    for (int i = 0; i < 10; i++) begin
      pulse_gap(3007);
      if (i == 4) chk(int'(freq) == 3004, "R3 sliding average", freq, 3004);
    end
    chk(int'(freq) == 3007, "R3 drift tracked", freq, 3007);
    // out-of-tolerance edge followed by a long gap
    pulse_gap(3150);
    pulse_gap(6000);
    chk(hold == 1, "R7 timeout holdover", hold, 1);
    chk(int'(freq) == 3007, "R4 out of tolerance ignored", freq, 3007);
    pulse_gap(3007);
    chk(hold == 1, "R2 restart edge not accepted", hold, 1);
    pulse_gap(3007);
    chk(hold == 0, "R7 accepted clears holdover", hold, 0);
    // reference declared invalid
    rv = 0;
    @(negedge clk);
    @(negedge clk);
    chk(hold == 1, "R8 invalid forces holdover", hold, 1);
    tick_seen = 0;
    pulse_gap(3007);
    chk(tick_seen >= 999 && tick_seen <= 1001, "R6 ticks in holdover", tick_seen, 1000);
    pulse_gap(1000);
    chk(int'(freq) == 3007, "R8 edges ignored", freq, 3007);
    rv = 1;
    pulse_gap(3007);
    pulse_gap(3007);
    chk(hold == 0, "R8 relock after valid", hold, 0);
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule